// File: doc/BRIEF.md
# Single-Step Accumulator Execute Unit

This block is the data half of a tiny 4-bit processor. It has an accumulator, a 16-word by 4-bit scratchpad and a function-select ALU. On each clock edge where the step enable is high, it takes one already-decoded instruction word. It then either combines the accumulator with an operand and writes the result back, or copies the accumulator into the scratchpad. The operand is either the immediate field of the instruction or a scratchpad word. Program sequencing sits outside the block. It reads the zero flag to make its conditional decisions and supplies the next instruction word.

The instruction is 16 bits wide, made of an upper control byte and a lower data byte. Arithmetic functions run when the mode bit is low, and they use the carry-in bit as the low-order input to the adder. Bitwise and transfer functions run when the mode bit is high. The scratchpad stores data inverted and returns it inverted (active-low). The operand path inverts it again, so instructions always see the true value. All arithmetic is modulo 16. The carry of the last arithmetic step is held on a separate output and never alters the accumulator.

Top module: `acc_exec_top`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator and carry become 0, whatever `step_en` and `instr` are.
- R2: With `step_en` low, an edge changes neither the accumulator, the carry nor any scratchpad word.
- R3: The instruction layout is: bit 15 selects the operand (1 = scratchpad word at the address, 0 = immediate); bit 14 is the write bit; bit 13 is the mode (0 = arithmetic, 1 = bitwise/transfer); bit 12 is carry-in; bits 11:8 are the function code; bits 7:4 are the immediate; bits 3:0 are the scratchpad address.
- R4: In arithmetic mode, function code 0 gives A+cin, 1 gives A+A+cin, 2 gives A+B+cin and 3 gives A+(15-B)+cin. The low 4 bits go to the accumulator and bit 4 goes to the carry. With cin=1, code 3 subtracts, and the carry is 1 exactly when A >= B.
- R5: In bitwise mode, function code 0 keeps A, 1 writes the complement of A, 2 loads B, 3 writes A AND B and 4 writes A OR B. Each of these clears the carry.
- R6: A step with the write bit set stores the accumulator at the address. It leaves the accumulator and carry unchanged, and a later load from that address returns the stored value.
- R7: When reset and a write step fall on the same edge, reset wins: the scratchpad word is not written.
- R8: `zero_o` is high exactly when the accumulator is 0.
- R9: Unused function codes (arithmetic codes 4-15, bitwise codes 5-15) keep the accumulator and clear the carry.
- R10: The sequence LDI 4, STORE 10, LDI 1, LOAD 10 leaves 4, and a following LDI 2, ADD 10 leaves 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Executes `instr` at this edge when high |
| instr | input | 16 | Decoded instruction word |
| acc_o | output | 4 | Accumulator |
| zero_o | output | 1 | High when the accumulator is 0 |
| carry_o | output | 1 | Carry of the last executed instruction |

## Verification
Two functions can collide on one edge: a scratchpad write and a synchronous reset. The bench sets up this clash on purpose. It loads a known value into the accumulator, then issues a write to an address that already holds a different value, with `rst` held high on that same edge. The outcome is judged by a later load from that address: it must return the old word, while the accumulator reads 0. A second overlap is a write to an address followed on the very next step by a read of it. This is judged against the behavioural model, which compares the outputs after every step.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;

    // Control byte, decoded from the top eight bits of the instruction.
    typedef struct packed {
        logic       use_ram;    // operand from scratchpad
        logic       ram_wr;     // store accumulator
        logic       logic_mode; // 1 = bitwise/transfer
        logic       cin;        // adder carry-in
        logic [3:0] fsel;       // function code
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [3:0] {
        AF_PASS   = 4'd0,
        AF_DOUBLE = 4'd1,
        AF_ADD    = 4'd2,
        AF_SUB    = 4'd3
    } arith_fn_e;

    typedef enum logic [3:0] {
        LF_KEEP = 4'd0,
        LF_INV  = 4'd1,
        LF_LOAD = 4'd2,
        LF_AND  = 4'd3,
        LF_OR   = 4'd4
    } logic_fn_e;

endpackage

// File: rtl/acc_decode.sv
`timescale 1ns/1ps
module acc_decode
    import acc_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 4,
    localparam int INSTR_W = CTL_W + DATA_W + ADDR_W
) (
    input  logic [INSTR_W-1:0] instr_i,
    output ctl_t               ctl_o,
    output logic [DATA_W-1:0]  imm_o,
    output logic [ADDR_W-1:0]  addr_o
);

    // Field split: control byte on top, then immediate, then address.
    always_comb begin
        ctl_o  = ctl_t'(instr_i[INSTR_W-1 -: CTL_W]);
        imm_o  = instr_i[ADDR_W +: DATA_W];
        addr_o = instr_i[0 +: ADDR_W];
    end

endmodule

// File: rtl/acc_scratch_ram.sv
`timescale 1ns/1ps
module acc_scratch_ram #(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_n_o  // active-low read data
);

    logic [DATA_W-1:0] word_q [DEPTH];

    // One register per word; each cell keeps the complement of its value.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        logic [DATA_W-1:0] word_d;
        logic              hit;

        always_comb begin
            hit    = wr_en_i && (addr_i == ADDR_W'(gi));
            word_d = hit ? ~wdata_i : word_q[gi];
        end

        always_ff @(posedge clk) begin
            word_q[gi] <= word_d;
        end
    end

    always_comb begin
        rdata_n_o = word_q[addr_i];
    end

endmodule

// File: rtl/acc_operand_mux.sv
`timescale 1ns/1ps
module acc_operand_mux #(
    parameter int DATA_W = 4
) (
    input  logic              use_ram_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic [DATA_W-1:0] ram_n_i,
    output logic [DATA_W-1:0] operand_o
);

    logic [DATA_W-1:0] ram_true;

    always_comb begin
        ram_true  = ~ram_n_i;  // restore polarity of scratchpad data
        operand_o = use_ram_i ? ram_true : imm_i;
    end

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int SUM_W = DATA_W + 1
) (
    input  ctl_t              ctl_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);

    logic [DATA_W-1:0] addend;
    logic              arith_known;
    logic [SUM_W-1:0]  sum;

    // Arithmetic path: choose the second adder input, then add with carry-in.
    always_comb begin
        addend      = '0;
        arith_known = 1'b1;
        case (arith_fn_e'(ctl_i.fsel))
            AF_PASS:   addend = '0;
            AF_DOUBLE: addend = a_i;
            AF_ADD:    addend = b_i;
            AF_SUB:    addend = ~b_i;
            default:   arith_known = 1'b0;
        endcase
        sum = {1'b0, a_i} + {1'b0, addend} + {{DATA_W{1'b0}}, ctl_i.cin};
    end

    // Result select; bitwise mode and unknown codes leave the carry at 0.
    always_comb begin
        res_o   = a_i;
        carry_o = 1'b0;
        if (!ctl_i.logic_mode) begin
            if (arith_known) begin
                res_o   = sum[DATA_W-1:0];
                carry_o = sum[DATA_W];
            end
        end else begin
            case (logic_fn_e'(ctl_i.fsel))
                LF_KEEP: res_o = a_i;
                LF_INV:  res_o = ~a_i;
                LF_LOAD: res_o = b_i;
                LF_AND:  res_o = a_i & b_i;
                LF_OR:   res_o = a_i | b_i;
                default: res_o = a_i;
            endcase
        end
    end

endmodule

// File: rtl/acc_exec_top.sv
`timescale 1ns/1ps
module acc_exec_top
    import acc_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 4,
    localparam int INSTR_W = CTL_W + DATA_W + ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic [INSTR_W-1:0] instr,
    output logic [DATA_W-1:0]  acc_o,
    output logic               zero_o,
    output logic               carry_o
);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              carry;
    } state_t;

    state_t            st_d, st_q;
    ctl_t              ctl;
    logic [DATA_W-1:0] imm;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] ram_n;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] alu_res;
    logic              alu_carry;
    logic              ram_we;

    acc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_decode (
        .instr_i (instr),
        .ctl_o   (ctl),
        .imm_o   (imm),
        .addr_o  (addr)
    );

    acc_scratch_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ram (
        .clk       (clk),
        .wr_en_i   (ram_we),
        .addr_i    (addr),
        .wdata_i   (st_q.acc),
        .rdata_n_o (ram_n)
    );

    acc_operand_mux #(.DATA_W(DATA_W)) i_mux (
        .use_ram_i (ctl.use_ram),
        .imm_i     (imm),
        .ram_n_i   (ram_n),
        .operand_o (operand)
    );

    acc_alu #(.DATA_W(DATA_W)) i_alu (
        .ctl_i   (ctl),
        .a_i     (st_q.acc),
        .b_i     (operand),
        .res_o   (alu_res),
        .carry_o (alu_carry)
    );

    // Next-state: reset dominates, then idle, then store, then ALU writeback.
    always_comb begin
        st_d   = st_q;
        ram_we = 1'b0;
        if (rst) begin
            st_d = '0;
        end else if (step_en) begin
            if (ctl.ram_wr) begin
                ram_we = 1'b1;
            end else begin
                st_d.acc   = alu_res;
                st_d.carry = alu_carry;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        acc_o   = st_q.acc;
        carry_o = st_q.carry;
        zero_o  = (st_q.acc == '0);
    end

endmodule

// File: rtl/acc_exec_chk.sv
`timescale 1ns/1ps
module acc_exec_chk #(
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              step_en,
    input logic [7:0]        ctl_byte,
    input logic [DATA_W-1:0] imm,
    input logic [DATA_W-1:0] acc_o,
    input logic              zero_o,
    input logic              carry_o
);

    logic       sel_ram, wr, mode, cin;
    logic [3:0] fn;
    assign sel_ram = ctl_byte[7];
    assign wr      = ctl_byte[6];
    assign mode    = ctl_byte[5];
    assign cin     = ctl_byte[4];
    assign fn      = ctl_byte[3:0];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && !carry_o)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(acc_o) && $stable(carry_o))); // R2

    AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (step_en && wr) |=> ($stable(acc_o) && $stable(carry_o))); // R6

    AST_IMM_LOAD: assert property (@(posedge clk) disable iff (rst)
        (step_en && !wr && !sel_ram && mode && fn == 4'd2) |=> (acc_o == $past(imm))); // R3

    AST_BITWISE_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (step_en && !wr && mode) |=> !carry_o); // R5

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (step_en && !wr && !mode && !cin && fn == 4'd0) |=> ($stable(acc_o) && !carry_o)); // R4

    AST_ZERO_AFTER_LOAD0: assert property (@(posedge clk) disable iff (rst)
        (step_en && !wr && !sel_ram && mode && fn == 4'd2 && imm == '0) |=> zero_o); // R8

endmodule

bind acc_exec_top acc_exec_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .ctl_byte (instr[INSTR_W-1 -: 8]),
    .imm      (instr[ADDR_W +: DATA_W]),
    .acc_o    (acc_o),
    .zero_o   (zero_o),
    .carry_o  (carry_o)
);

// File: tb/test_acc_exec_top.sv
`timescale 1ns/1ps
module test_acc_exec_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        step_en;
    logic [15:0] instr;
    logic [3:0]  acc_o;
    logic        zero_o;
    logic        carry_o;

    int n_tests = 0;
    int n_fail  = 0;
    int m_acc   = 0;
    int m_c     = 0;
    int m_ram [16];

    always #2.5 clk = ~clk;

    acc_exec_top i_acc_exec_top (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .instr   (instr),
        .acc_o   (acc_o),
        .zero_o  (zero_o),
        .carry_o (carry_o)
    );

    function automatic logic [15:0] mk(bit sel, bit we, bit m, bit ci, int f, int imm, int adr);
        return {sel, we, m, ci, 4'(f), 4'(imm), 4'(adr)};
    endfunction

    // Behavioural reference of one edge.
    task automatic model(bit r, bit en, logic [15:0] ins);
        int b, s, f, a;
        if (r) begin
            m_acc = 0; m_c = 0;
        end else if (en) begin
            f = int'(ins[11:8]);
            a = int'(ins[3:0]);
            b = ins[15] ? m_ram[a] : int'(ins[7:4]);
            if (ins[14]) begin
                m_ram[a] = m_acc;
            end else if (!ins[13]) begin
                s = -1;
                if (f == 0) s = m_acc + int'(ins[12]);
                if (f == 1) s = 2 * m_acc + int'(ins[12]);
                if (f == 2) s = m_acc + b + int'(ins[12]);
                if (f == 3) s = m_acc + (15 - b) + int'(ins[12]);
                if (s < 0) m_c = 0;
                else begin m_acc = s % 16; m_c = s / 16; end
            end else begin
                m_c = 0;
                if (f == 1) m_acc = 15 - m_acc;
                if (f == 2) m_acc = b;
                if (f == 3) m_acc = m_acc & b;
                if (f == 4) m_acc = m_acc | b;
            end
        end
    endtask

    task automatic check(string tag);
        n_tests++;
        if (acc_o !== 4'(m_acc) || carry_o !== 1'(m_c) || zero_o !== (m_acc == 0)) begin
            n_fail++;
            $display("FAIL %s: acc=%0d carry=%0d zero=%0d expected acc=%0d carry=%0d zero=%0d",
                     tag, acc_o, carry_o, zero_o, m_acc, m_c, (m_acc == 0));
        end
    endtask

    task automatic step(bit r, bit en, logic [15:0] ins, string tag);
        rst = r; step_en = en; instr = ins;
        @(posedge clk);
        model(r, en, ins);
        @(negedge clk);
        check(tag);
    endtask

    function automatic string tag_of(bit r, bit en, logic [15:0] ins);
        if (r) return "R1";
        if (!en) return "R2";
        if (ins[14]) return "R6";
        if (!ins[13]) return (ins[11:8] > 3) ? "R9" : "R4";
        return (ins[11:8] > 4) ? "R9" : "R5";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; step_en = 1'b0; instr = '0;
        @(negedge clk);
        step(1, 1, mk(0, 0, 1, 0, 2, 9, 0), "R1");     // reset beats load
        step(0, 1, mk(0, 0, 1, 0, 2, 0, 0), "R8");     // LDI 0 -> zero flag
        for (int i = 0; i < 16; i++) begin
            step(0, 1, mk(0, 0, 1, 0, 2, (i * 7 + 3) % 16, 0), "R3");
            step(0, 1, mk(0, 1, 0, 0, 0, 0, i), "R6");
        end
        // R10 program
        step(0, 1, mk(0, 0, 1, 0, 2, 4, 0), "R10");
        step(0, 1, mk(0, 1, 0, 0, 0, 0, 10), "R10");
        step(0, 1, mk(0, 0, 1, 0, 2, 1, 0), "R10");
        step(0, 1, mk(1, 0, 1, 0, 2, 0, 10), "R10");
        if (acc_o !== 4'd4) begin n_fail++; $display("FAIL R10: acc=%0d expected 4", acc_o); end
        n_tests++;
        step(0, 1, mk(0, 0, 1, 0, 2, 2, 0), "R10");
        step(1'b0, 1'b1, mk(1, 0, 0, 0, 2, 0, 10), "R10");
        if (acc_o !== 4'd6) begin n_fail++; $display("FAIL R10: acc=%0d expected 6", acc_o); end
        n_tests++;
        // R2: idle edge ignores load and store
        step(0, 0, mk(0, 0, 1, 0, 2, 9, 0), "R2");
        step(0, 1, mk(0, 0, 1, 0, 2, 13, 0), "R2");
        step(0, 0, mk(0, 1, 0, 0, 0, 0, 3), "R2");
        step(0, 1, mk(1, 0, 1, 0, 2, 0, 3), "R2");
        // R7: reset collides with store; old word survives
        step(0, 1, mk(0, 0, 1, 0, 2, 5, 0), "R7");
        step(1, 1, mk(0, 1, 0, 0, 0, 0, 6), "R7");
        step(0, 1, mk(1, 0, 1, 0, 2, 0, 6), "R7");
        // R4 corners: wrap, borrow, equal subtract, shift
        step(0, 1, mk(0, 0, 1, 0, 2, 15, 0), "R4");
        step(0, 1, mk(0, 0, 0, 0, 2, 1, 0), "R4");     // 15+1 -> 0, carry
        step(0, 1, mk(0, 0, 1, 0, 2, 3, 0), "R4");
        step(0, 1, mk(0, 0, 0, 1, 3, 5, 0), "R4");     // 3-5 -> 14, no carry
        step(0, 1, mk(0, 0, 0, 1, 3, 14, 0), "R4");    // 14-14 -> 0, carry
        step(0, 1, mk(0, 0, 1, 0, 2, 9, 0), "R4");
        step(0, 1, mk(0, 0, 0, 0, 1, 0, 0), "R4");     // shift 9 -> 2, carry
        step(0, 1, mk(0, 0, 1, 0, 1, 0, 0), "R5");     // invert
        step(0, 1, mk(0, 0, 0, 1, 0, 0, 0), "R4");     // pass with cin
        // R9: unused codes
        step(0, 1, mk(0, 0, 1, 0, 2, 15, 0), "R9");
        step(0, 1, mk(0, 0, 0, 0, 2, 15, 0), "R9");
        step(0, 1, mk(0, 0, 0, 0, 7, 4, 0), "R9");
        step(0, 1, mk(0, 0, 1, 0, 11, 4, 0), "R9");
        // Random mix
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] ins;
            bit r, en;
            ins = 16'($urandom);
            r   = ($urandom % 50) == 0;
            en  = ($urandom % 8) != 0;
            step(r, en, ins, tag_of(r, en, ins));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule